// File: doc/BRIEF.md
# Two-Way Write-Through Cache Controller

This block is a blocking cache with two ways per set, placed between a requester and a slower next-level memory. Each cycle the requester presents an address, a read/write flag and write data. The tags and valid bits of both ways in the indexed set are looked up at once, together with the addressed word of each way. A read that matches returns the word in the same cycle. A read that does not match raises a stall. The stall is recomputed every cycle from the live lookup, so the requester holds the same request until the lookup turns into a hit.

A small two-state controller serves one read miss at a time. It records the block address and the chosen way, then holds a whole-block read request towards memory. When the response arrives it writes the block, its tag and a valid bit into that way. Stores go straight through to memory as single-word writes. A store that hits also updates the cached word. A store that misses leaves the cache untouched. Each set holds one replacement bit. Every hit and every fill sets that bit to point at the other way. An empty way is filled before this bit is consulted.

Top module: `twoway_wt_cache`

## Requirements
- R1: A byte address is split from bit 0 upward into a block offset of log2(BLOCK_BYTES) bits, a set index of log2(SETS) bits and a tag made of the remaining upper bits. With the defaults (32-byte blocks, 64 sets) the offset is [4:0], the index is [10:5] and the tag is [31:11]. Bits [4:2] select the 32-bit word in the block.
- R2: Reset clears every valid bit and every replacement bit. After reset no memory request is active, and the first read of any address misses.
- R3: `rsp_hit` is high in the cycle a request is presented, while the controller is idle, if either way of the indexed set is valid and holds the request's tag. On a read hit, `rsp_rdata` carries the addressed word in that same cycle.
- R4: A read miss makes the controller issue one whole-block request on `mem_rd_req`, with an address whose low offset bits are zero. The request and its address stay unchanged until `mem_rd_valid`. `rsp_stall` stays high from the miss cycle to the response cycle inclusive. In the cycle after the response, the same read returns a hit with the filled data.
- R5: While a fill is outstanding, every request stalls, reads and writes alike. Such a request causes no memory write and changes no cached word.
- R6: After every read hit, write hit or fill, the set's replacement bit names the way that was not used. When both ways are valid, a miss fills the way that this bit names.
- R7: A miss fills an invalid way before the way named by the replacement bit, and way 0 before way 1 when both ways are invalid.
- R8: A write hit updates the addressed word in the cache and asserts `mem_wr_req` with the request's address and data in the same cycle. It does not stall and `rsp_hit` is high.
- R9: A write miss asserts `mem_wr_req` with the request's address and data, does not stall, keeps `rsp_hit` low and allocates nothing. A later read of that address still misses.
- R10: Over a sequence of three conflicting blocks in one set, mixed with reads and writes, the hit/miss pattern and the returned data agree with a two-way LRU model backed by memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | DATA_W | Store data |
| rsp_hit | output | 1 | Lookup matched a valid way (idle only) |
| rsp_rdata | output | DATA_W | Word read from the matching way |
| rsp_stall | output | 1 | Request must be held and retried |
| mem_rd_req | output | 1 | Whole-block read request to next level |
| mem_rd_addr | output | ADDR_W | Block-aligned address of the block read |
| mem_rd_valid | input | 1 | Block read response present |
| mem_rd_data | input | BLOCK_BYTES*8 | Block contents, word 0 in the low bits |
| mem_wr_req | output | 1 | Single-word write to next level |
| mem_wr_addr | output | ADDR_W | Byte address of the word write |
| mem_wr_data | output | DATA_W | Data of the word write |

## Verification
The hardest state to reach from the ports is a request that changes while a fill is still outstanding. The requester normally holds its access, so no request ever differs from the one that missed. The bench starts a read miss and, during the fetch cycles, swaps the request for a store to a block that is already cached. It checks that this store is stalled and produces no memory write. It then restores the original read, and a later read of the stored word proves that the word was not changed. Replacement order is reached with three tags that share one set. Hits placed between the misses make the result depend on whether hits update the replacement bit.

// File: rtl/twc_pkg.sv
package twc_pkg;
   localparam int TWC_WAYS = 2;

   typedef enum logic {
      TWC_IDLE  = 1'b0,
      TWC_FETCH = 1'b1
   } twc_state_e;
endpackage

// File: rtl/twc_tag_array.sv
module twc_tag_array #(
   parameter int IDX_W = 6,
   parameter int TAG_W = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic [1:0]       lk_hit,
   output logic [1:0]       lk_valid,
   output logic             lk_lru,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic             fill_way,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             touch_en,
   input  logic             touch_way
);
   localparam int SETS = 1 << IDX_W;

   logic [SETS-1:0] lru_q;

   for (genvar w = 0; w < twc_pkg::TWC_WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tag_q [SETS];
      logic [SETS-1:0]  vld_q;
      logic             sel;

      assign sel = fill_en && (fill_way == 1'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   vld_q <= '0;
         else if (sel) vld_q[fill_idx] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) tag_q[fill_idx] <= fill_tag;
      end

      assign lk_valid[w] = vld_q[lk_idx];
      assign lk_hit[w]   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lru_q <= '0;
      else if (fill_en)  lru_q[fill_idx] <= ~fill_way;
      else if (touch_en) lru_q[lk_idx]   <= ~touch_way;
   end

   assign lk_lru = lru_q[lk_idx];

   // R3: a tag is never resident in both ways of a set
   p_onehot_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hit));

   // R6: a fill leaves the set pointing at the other way
   p_lru_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (lru_q[$past(fill_idx)] != $past(fill_way)));

   // R6: a hit leaves the set pointing at the other way
   p_lru_touch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_en && !fill_en) |=> (lru_q[$past(lk_idx)] != $past(touch_way)));
endmodule

// File: rtl/twc_data_array.sv
module twc_data_array #(
   parameter int IDX_W  = 6,
   parameter int WSEL_W = 3,
   parameter int DATA_W = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [IDX_W-1:0]                rd_idx,
   input  logic [WSEL_W-1:0]               rd_word,
   input  logic                            rd_way,
   output logic [DATA_W-1:0]               rd_data,
   input  logic                            fill_en,
   input  logic [IDX_W-1:0]                fill_idx,
   input  logic                            fill_way,
   input  logic [(DATA_W<<WSEL_W)-1:0]     fill_data,
   input  logic                            wr_en,
   input  logic                            wr_way,
   input  logic [DATA_W-1:0]               wr_data
);
   localparam int SETS    = 1 << IDX_W;
   localparam int BLOCK_W = DATA_W << WSEL_W;

   logic [DATA_W-1:0] way_word [twc_pkg::TWC_WAYS];

   for (genvar w = 0; w < twc_pkg::TWC_WAYS; w++) begin : g_way
      logic [BLOCK_W-1:0] blk_q [SETS];

      always_ff @(posedge clk) begin
         if (fill_en && (fill_way == 1'(w)))
            blk_q[fill_idx] <= fill_data;
         else if (wr_en && (wr_way == 1'(w)))
            blk_q[rd_idx][rd_word*DATA_W +: DATA_W] <= wr_data;
      end

      assign way_word[w] = blk_q[rd_idx][rd_word*DATA_W +: DATA_W];
   end

   assign rd_data = way_word[rd_way];

   // R5: a word update never coincides with a block fill
   p_fill_vs_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_en && wr_en));
endmodule

// File: rtl/twc_miss_fsm.sv
module twc_miss_fsm #(
   parameter int BLK_W = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss_go,
   input  logic [BLK_W-1:0] miss_blk,
   input  logic             miss_way,
   input  logic             rsp_valid,
   output logic             busy,
   output logic             mem_req,
   output logic [BLK_W-1:0] mem_blk,
   output logic             fill_en,
   output logic             fill_way
);
   import twc_pkg::*;

   twc_state_e       state_q;
   logic [BLK_W-1:0] blk_q;
   logic             way_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TWC_IDLE;
         blk_q   <= '0;
         way_q   <= 1'b0;
      end else begin
         case (state_q)
            TWC_IDLE: begin
               if (miss_go) begin
                  blk_q   <= miss_blk;
                  way_q   <= miss_way;
                  state_q <= TWC_FETCH;
               end
            end
            TWC_FETCH: begin
               if (rsp_valid) state_q <= TWC_IDLE;
            end
            default: state_q <= TWC_IDLE;
         endcase
      end
   end

   assign busy     = (state_q == TWC_FETCH);
   assign mem_req  = busy;
   assign mem_blk  = blk_q;
   assign fill_en  = busy && rsp_valid;
   assign fill_way = way_q;

   // R4: the block request is held until memory answers
   p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !rsp_valid) |=> mem_req);

   // R4: the block address does not move while waiting
   p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !rsp_valid) |=> $stable(mem_blk));

   // R4: one response ends the fetch
   p_fill_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> !busy);
endmodule

// File: rtl/twoway_wt_cache.sv
module twoway_wt_cache #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int BLOCK_BYTES = 32,
   parameter int SETS        = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     rsp_hit,
   output logic [DATA_W-1:0]        rsp_rdata,
   output logic                     rsp_stall,
   output logic                     mem_rd_req,
   output logic [ADDR_W-1:0]        mem_rd_addr,
   input  logic                     mem_rd_valid,
   input  logic [BLOCK_BYTES*8-1:0] mem_rd_data,
   output logic                     mem_wr_req,
   output logic [ADDR_W-1:0]        mem_wr_addr,
   output logic [DATA_W-1:0]        mem_wr_data
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam int WORDS      = BLOCK_BYTES / WORD_BYTES;
   localparam int OFF_W      = $clog2(BLOCK_BYTES);
   localparam int BSEL_W     = $clog2(WORD_BYTES);
   localparam int WSEL_W     = $clog2(WORDS);
   localparam int IDX_W      = $clog2(SETS);
   localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
   localparam int BLK_W      = ADDR_W - OFF_W;

   if ((BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_chk_blk
      $error("BLOCK_BYTES must be a power of two");
   end
   if ((SETS & (SETS - 1)) != 0 || SETS < 2) begin : g_chk_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (DATA_W % 8 != 0 || WORDS < 2) begin : g_chk_word
      $error("a block must hold at least two whole words");
   end
   if (TAG_W < 1) begin : g_chk_tag
      $error("address too narrow for the chosen geometry");
   end

   logic [IDX_W-1:0]  lk_idx;
   logic [TAG_W-1:0]  lk_tag;
   logic [WSEL_W-1:0] lk_word;
   logic [1:0]        way_hit;
   logic [1:0]        way_vld;
   logic              set_lru;
   logic              any_hit;
   logic              hit_way;
   logic              victim;
   logic              busy;
   logic              rd_miss;
   logic              wr_hit;
   logic              fill_en;
   logic              fill_way;
   logic [BLK_W-1:0]  fetch_blk;
   logic [BSEL_W-1:0] unused_bsel;

   assign lk_word     = req_addr[BSEL_W +: WSEL_W];
   assign lk_idx      = req_addr[OFF_W +: IDX_W];
   assign lk_tag      = req_addr[ADDR_W-1 -: TAG_W];
   assign unused_bsel = req_addr[BSEL_W-1:0];

   assign any_hit = |way_hit;
   assign hit_way = way_hit[1];
   assign victim  = !way_vld[0] ? 1'b0 : (!way_vld[1] ? 1'b1 : set_lru);

   assign rsp_hit   = req_valid && !busy && any_hit;
   assign rd_miss   = req_valid && !busy && !req_write && !any_hit;
   assign wr_hit    = req_valid && !busy && req_write && any_hit;
   assign rsp_stall = req_valid && (busy || (!req_write && !any_hit));

   assign mem_wr_req  = req_valid && !busy && req_write;
   assign mem_wr_addr = req_addr;
   assign mem_wr_data = req_wdata;

   assign mem_rd_addr = {fetch_blk, {OFF_W{1'b0}}};

   twc_tag_array #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_idx    (lk_idx),
      .lk_tag    (lk_tag),
      .lk_hit    (way_hit),
      .lk_valid  (way_vld),
      .lk_lru    (set_lru),
      .fill_en   (fill_en),
      .fill_idx  (fetch_blk[IDX_W-1:0]),
      .fill_way  (fill_way),
      .fill_tag  (fetch_blk[BLK_W-1 -: TAG_W]),
      .touch_en  (rsp_hit),
      .touch_way (hit_way)
   );

   twc_data_array #(
      .IDX_W  (IDX_W),
      .WSEL_W (WSEL_W),
      .DATA_W (DATA_W)
   ) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (lk_idx),
      .rd_word   (lk_word),
      .rd_way    (hit_way),
      .rd_data   (rsp_rdata),
      .fill_en   (fill_en),
      .fill_idx  (fetch_blk[IDX_W-1:0]),
      .fill_way  (fill_way),
      .fill_data (mem_rd_data),
      .wr_en     (wr_hit),
      .wr_way    (hit_way),
      .wr_data   (req_wdata)
   );

   twc_miss_fsm #(
      .BLK_W (BLK_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .miss_go   (rd_miss),
      .miss_blk  (req_addr[ADDR_W-1:OFF_W]),
      .miss_way  (victim),
      .rsp_valid (mem_rd_valid),
      .busy      (busy),
      .mem_req   (mem_rd_req),
      .mem_blk   (fetch_blk),
      .fill_en   (fill_en),
      .fill_way  (fill_way)
   );

   // R3: hit and stall are mutually exclusive
   p_hit_not_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> !rsp_stall);

   // R9: stores never stall while idle
   p_store_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !busy) |-> !rsp_stall);

   // R5: no write-through while a fill is outstanding
   p_busy_no_wt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !mem_wr_req);

   // R4: an idle read miss starts a block fetch next cycle
   p_miss_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !mem_rd_req && rsp_stall) |=> mem_rd_req);

   // R7: an empty way is never passed over for a full one
   p_victim_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_miss && (way_vld != 2'b11)) |-> !way_vld[victim]);
endmodule

// File: tb/twoway_wt_cache_tb_top.sv
`timescale 1ns/1ps
module twoway_wt_cache_tb_top;
   localparam int LAT = 3;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         req_valid, req_write;
   logic [31:0]  req_addr, req_wdata;
   logic         rsp_hit, rsp_stall;
   logic [31:0]  rsp_rdata;
   logic         mem_rd_req, mem_rd_valid;
   logic [31:0]  mem_rd_addr;
   logic [255:0] mem_rd_data;
   logic         mem_wr_req;
   logic [31:0]  mem_wr_addr, mem_wr_data;

   int checks = 0, failures = 0, rd_reqs = 0;
   bit done = 1'b0;
   logic [31:0] wmem [logic [31:0]];

   always #4 clk = ~clk;

   twoway_wt_cache dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata), .rsp_stall(rsp_stall),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data)
   );

   function automatic logic [31:0] pat(logic [31:0] a);
      return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'h1234_5678;
   endfunction

   function automatic logic [31:0] expw(logic [31:0] a);
      logic [31:0] k;
      k = {a[31:2], 2'b00};
      if (wmem.exists(k)) return wmem[k];
      return pat(k);
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // next-level memory: records word writes
   always @(posedge clk) begin
      if (rst_n && mem_wr_req) wmem[{mem_wr_addr[31:2], 2'b00}] = mem_wr_data;
   end

   // next-level memory: answers block reads after LAT cycles
   initial begin
      mem_rd_valid = 1'b0;
      mem_rd_data  = '0;
      forever begin
         @(negedge clk);
         if (rst_n && mem_rd_req) begin
            rd_reqs++;
            chk(mem_rd_addr[4:0] == 5'd0, "R4 block address aligned",
                mem_rd_addr, {mem_rd_addr[31:5], 5'd0});
            repeat (LAT) @(negedge clk);
            for (int k = 0; k < 8; k++)
               mem_rd_data[k*32 +: 32] = expw(mem_rd_addr + 32'(k * 4));
            mem_rd_valid = 1'b1;
            @(negedge clk);
            mem_rd_valid = 1'b0;
         end
      end
   end

   task automatic do_acc(input bit w, input logic [31:0] a, input logic [31:0] d,
                         output bit hit0, output bit wt0, output int waits,
                         output logic [31:0] rd);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      #1;
      hit0 = rsp_hit; wt0 = mem_wr_req; waits = 0;
      while (rsp_stall && waits < 100) begin
         @(negedge clk); #1;
         waits++;
      end
      rd = rsp_rdata;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   // {write, expected hit, address, write data}
   localparam logic [65:0] VEC [16] = '{
      {1'b0, 1'b0, 32'h0000_0060, 32'h0},
      {1'b0, 1'b1, 32'h0000_0064, 32'h0},
      {1'b0, 1'b0, 32'h0000_0860, 32'h0},
      {1'b0, 1'b1, 32'h0000_0068, 32'h0},
      {1'b0, 1'b0, 32'h0000_1060, 32'h0},
      {1'b0, 1'b1, 32'h0000_0060, 32'h0},
      {1'b0, 1'b0, 32'h0000_0860, 32'h0},
      {1'b0, 1'b0, 32'h0000_1064, 32'h0},
      {1'b1, 1'b1, 32'h0000_086C, 32'hDEAD_0001},
      {1'b0, 1'b1, 32'h0000_086C, 32'h0},
      {1'b1, 1'b0, 32'h0000_0070, 32'hBEEF_0002},
      {1'b0, 1'b0, 32'h0000_0070, 32'h0},
      {1'b0, 1'b0, 32'h0000_1060, 32'h0},
      {1'b0, 1'b1, 32'h0000_0070, 32'h0},
      {1'b0, 1'b0, 32'h0000_0000, 32'h0},
      {1'b0, 1'b1, 32'h0000_001C, 32'h0}
   };

   initial begin
      bit hit0, wt0;
      int waits, exp_miss, got_miss, wt;
      logic [31:0] rd;
      logic [31:0] x;

      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!rsp_stall && !rsp_hit, "R2 idle outputs after reset",
          {30'd0, rsp_stall, rsp_hit}, 32'd0);
      chk(!mem_rd_req && !mem_wr_req, "R2 no memory traffic after reset",
          {30'd0, mem_rd_req, mem_wr_req}, 32'd0);

      exp_miss = 0; got_miss = 0;
      for (int i = 0; i < 16; i++) begin
         do_acc(VEC[i][65], VEC[i][63:32], VEC[i][31:0], hit0, wt0, waits, rd);
         if (VEC[i][65]) begin
            chk(hit0 == VEC[i][64], "R8 R9 store hit flag", 32'(hit0), 32'(VEC[i][64]));
            chk(wt0, "R8 R9 store written through", 32'(wt0), 32'd1);
            chk(waits == 0, "R8 R9 store without stall", 32'(waits), 32'd0);
         end else begin
            if (!VEC[i][64]) exp_miss++;
            if (!hit0) got_miss++;
            chk(hit0 == VEC[i][64], "R1 R2 R6 R7 R10 hit pattern", 32'(hit0), 32'(VEC[i][64]));
            chk(rd == expw(VEC[i][63:32]), "R3 R10 read data", rd, expw(VEC[i][63:32]));
            if (!VEC[i][64])
               chk(waits == LAT + 2, "R4 stall length on miss", 32'(waits), 32'(LAT + 2));
         end
      end
      chk(got_miss == exp_miss, "R10 miss count", 32'(got_miss), 32'(exp_miss));
      chk(rd_reqs == exp_miss, "R4 R9 block requests", 32'(rd_reqs), 32'(exp_miss));

      // R5: a store that appears during a fetch is stalled and dropped
      x = 32'h0000_2040;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = x;
      #1;
      chk(rsp_stall, "R4 miss stalls", 32'(rsp_stall), 32'd1);
      @(negedge clk);
      req_write = 1'b1; req_addr = 32'h0000_0004; req_wdata = 32'h5555_AAAA;
      #1;
      chk(rsp_stall && !rsp_hit, "R5 store stalled during fetch",
          {30'd0, rsp_stall, rsp_hit}, 32'd2);
      chk(!mem_wr_req, "R5 no write-through during fetch", 32'(mem_wr_req), 32'd0);
      @(negedge clk);
      req_write = 1'b0; req_addr = x;
      wt = 0;
      #1;
      while (rsp_stall && wt < 100) begin @(negedge clk); #1; wt++; end
      chk(rsp_hit && rsp_rdata == expw(x), "R4 retried read hits after fill",
          rsp_rdata, expw(x));
      @(negedge clk);
      req_valid = 1'b0;
      do_acc(1'b0, 32'h0000_0004, 32'h0, hit0, wt0, waits, rd);
      chk(hit0 && rd == pat(32'h0000_0004), "R5 cached word unchanged",
          rd, pat(32'h0000_0004));

      // R2: reset invalidates a resident block
      do_acc(1'b0, 32'h0000_0070, 32'h0, hit0, wt0, waits, rd);
      chk(hit0, "R6 block resident before reset", 32'(hit0), 32'd1);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      do_acc(1'b0, 32'h0000_0070, 32'h0, hit0, wt0, waits, rd);
      chk(!hit0, "R2 miss after reset", 32'(hit0), 32'd0);
      chk(rd == expw(32'h0000_0070), "R2 data after refill", rd, expw(32'h0000_0070));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog R4 actual=%h expected=%h", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule